// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Front End

This block is the command side of a small serial EEPROM that a host drives over three wires: a chip select, a serial clock and a serial data input. The wires are sampled in the system clock domain, so the serial clock only needs to be slower than the system clock. While selected, the block waits for a start bit and then collects a two-bit opcode and an address, followed by a data word for writes. It then carries out a read, a write, a single-location erase, a whole-array erase, or a change to the write-enable latch, against an internal synchronous register-file array.

The array holds 2048 bytes. A width pin picks how the host sees them: as 16-bit words behind a 10-bit address, or as bytes behind an 11-bit address. Programming commands start a self-timed cycle that is counted in system clocks and needs no serial clock edges. That cycle also runs on if the host deselects. The serial output pin has an enable, so it floats when the block is not driving it. It carries read data, or the ready/busy state after a programming command.

Top module: `mw_eeprom_slave`

## Requirements
- R1: After reset and while chip select is low, `dout_oe` is low, the command logic returns to waiting for a start bit, and programming is disabled.
- R2: With chip select high and no start bit yet, serial clock rises with `din` low change nothing: `dout_oe` stays low and a later start bit begins a correctly aligned command.
- R3: Fields are sent MSB first and sampled on serial clock rises. After the start bit come a 2-bit opcode and the address (10 bits when `org_wide`=1, 11 bits when 0). The opcodes are: 10 read, 01 write, 11 erase, 00 special. On a read, `dout` goes to 0 with `dout_oe` high once the last address bit is taken. Each further rise then presents the next data bit, MSB first: 16 bits per word in wide mode, 8 in byte mode.
- R4: Clocking on after the last bit of a read delivers the following location without a new command. The address wraps from the top location to 0.
- R5: A write takes 16 data bits in wide mode and 8 in byte mode. Byte address b holds bits 7:0 of word b/2 when b is even, and bits 15:8 of that word when b is odd.
- R6: Erase sets the addressed word or byte to all ones. For a special command, the two bits after the opcode select the action: 11 enable, 00 disable, 10 erase-all, 01 no action. The rest of the address field is ignored. Erase-all sets the whole array to all ones.
- R7: Write, erase and erase-all have no effect, and start no program cycle, unless an enable has been received since reset or since the last disable, and `prog_en` is high.
- R8: An accepted programming command starts a program cycle of `PROG_CYCLES` system clocks. While chip select is high, `dout_oe` is high with `dout`=0 during the cycle and `dout`=1 after it. This status stays until the next accepted start bit.
- R9: Dropping chip select does not stop a running program cycle. The write completes, and reselecting shows the status again.
- R10: Start bits that arrive during a program cycle are ignored, and the status stays on `dout`.
- R11: Dropping chip select in the middle of a command abandons it. The next command decodes from a fresh start bit.
- R12: After a non-read command has been fully taken, further serial clock edges are ignored until chip select falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data from the host |
| org_wide | input | 1 | 1 selects 16-bit words, 0 selects bytes |
| prog_en | input | 1 | 1 allows programming, 0 blocks it |
| dout | output | 1 | Serial data or ready/busy status |
| dout_oe | output | 1 | Output enable for `dout`; low means high impedance |

## Verification
Commands are tried in both widths with address values that separate the modes. The top word and byte addresses and their wrap to zero show that the address length follows the width pin. Writing a byte and reading back the whole word shows which lane each byte address selects. A write blocked by `prog_en`, a write after a disable, and a write before any enable each leave the erased pattern in place, which sets the protection paths apart from one another. A deselect during the program cycle and a start bit sent while busy separate a cycle that runs on by itself from one that must be held by the host.

// File: rtl/mw_pkg.sv
package mw_pkg;

   typedef enum logic [1:0] {
      F_WAIT  = 2'd0,
      F_SHIFT = 2'd1,
      F_READ  = 2'd2,
      F_DONE  = 2'd3
   } front_st_e;

   typedef enum logic [1:0] {
      OP_SPECIAL = 2'b00,
      OP_WRITE   = 2'b01,
      OP_READ    = 2'b10,
      OP_ERASE   = 2'b11
   } opcode_e;

   localparam logic [1:0] SUB_DISABLE = 2'b00;
   localparam logic [1:0] SUB_ERALL   = 2'b10;
   localparam logic [1:0] SUB_ENABLE  = 2'b11;

   typedef struct packed {
      logic wr;
      logic er;
      logic eral;
      logic en;
      logic dis;
   } cmd_ev_t;

endpackage

// File: rtl/mw_cmd_front.sv
module mw_cmd_front
   import mw_pkg::*;
#(
   parameter int WORD_AW = 10,
   parameter int BYTE_W  = 8
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cs,
   input  logic                  sclk,
   input  logic                  din,
   input  logic                  org_wide,
   input  logic                  busy,
   input  logic [2*BYTE_W-1:0]   rd_data,
   output logic [WORD_AW:0]      rd_addr,
   output logic                  wide,
   output logic                  rd_active,
   output logic                  rd_bit,
   output logic                  start_seen,
   output cmd_ev_t               ev,
   output logic [WORD_AW:0]      cmd_addr,
   output logic [2*BYTE_W-1:0]   cmd_data
);
   localparam int ADDR_W = WORD_AW + 1;
   localparam int DW     = 2 * BYTE_W;
   localparam int CNT_W  = $clog2(2 + ADDR_W + DW + 1);
   localparam int BIDX_W = $clog2(DW);
   localparam logic [CNT_W-1:0] HDR16 = CNT_W'(2 + WORD_AW);
   localparam logic [CNT_W-1:0] HDR8  = CNT_W'(2 + ADDR_W);
   localparam logic [CNT_W-1:0] TOT16 = CNT_W'(2 + WORD_AW + DW);
   localparam logic [CNT_W-1:0] TOT8  = CNT_W'(2 + ADDR_W + BYTE_W);

   front_st_e           st;
   logic                sclk_q;
   logic                rise;
   logic [1:0]          op;
   logic [ADDR_W-1:0]   addr, addr_n, rd_inc, rd_nxt;
   logic [DW-1:0]       data, data_n, rd_sh;
   logic [CNT_W-1:0]    cnt, cnt_nx, hdr_len, tot_len;
   logic [BIDX_W-1:0]   bidx, wlast;
   logic [1:0]          sub;

   assign rise    = cs & sclk & ~sclk_q;
   assign addr_n  = {addr[ADDR_W-2:0], din};
   assign data_n  = {data[DW-2:0], din};
   assign cnt_nx  = cnt + 1'b1;
   assign hdr_len = wide ? HDR16 : HDR8;
   assign tot_len = wide ? TOT16 : TOT8;
   assign wlast   = wide ? BIDX_W'(DW - 1) : BIDX_W'(BYTE_W - 1);
   assign sub     = wide ? addr_n[WORD_AW-1 -: 2] : addr_n[ADDR_W-1 -: 2];
   assign rd_inc  = rd_addr + 1'b1;
   assign rd_nxt  = wide ? {1'b0, rd_inc[WORD_AW-1:0]} : rd_inc;
   assign rd_sh   = rd_data << bidx;
   assign rd_active = (st == F_READ);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= F_WAIT;  sclk_q <= 1'b0;  op <= '0;  addr <= '0;  data <= '0;
         cnt <= '0;  bidx <= '0;  wide <= 1'b1;  rd_addr <= '0;  rd_bit <= 1'b0;
         start_seen <= 1'b0;  ev <= '0;  cmd_addr <= '0;  cmd_data <= '0;
      end else begin
         sclk_q     <= sclk;
         ev         <= '0;
         start_seen <= 1'b0;
         if (!cs) begin
            st     <= F_WAIT;
            rd_bit <= 1'b0;
         end else if (rise) begin
            unique case (st)
               F_WAIT: if (din && !busy) begin
                  st <= F_SHIFT;  cnt <= '0;  op <= '0;  addr <= '0;  data <= '0;
                  wide <= org_wide;  start_seen <= 1'b1;
               end
               F_SHIFT: begin
                  cnt <= cnt_nx;
                  if (cnt < CNT_W'(2))     op   <= {op[0], din};
                  else if (cnt < hdr_len)  addr <= addr_n;
                  else                     data <= data_n;
                  if (cnt_nx == hdr_len) begin
                     unique case (opcode_e'(op))
                        OP_READ: begin
                           st <= F_READ;  rd_addr <= addr_n;  rd_bit <= 1'b0;  bidx <= '0;
                        end
                        OP_WRITE: ;
                        OP_ERASE: begin
                           ev.er <= 1'b1;  cmd_addr <= addr_n;  st <= F_DONE;
                        end
                        OP_SPECIAL: begin
                           st <= F_DONE;
                           if (sub == SUB_ENABLE)  ev.en   <= 1'b1;
                           if (sub == SUB_DISABLE) ev.dis  <= 1'b1;
                           if (sub == SUB_ERALL)   ev.eral <= 1'b1;
                        end
                     endcase
                  end else if (cnt_nx == tot_len) begin
                     ev.wr <= 1'b1;  cmd_addr <= addr;  cmd_data <= data_n;  st <= F_DONE;
                  end
               end
               F_READ: begin
                  rd_bit <= rd_sh[DW-1];
                  if (bidx == wlast) begin
                     bidx <= '0;  rd_addr <= rd_nxt;
                  end else begin
                     bidx <= bidx + 1'b1;
                  end
               end
               F_DONE: ;
            endcase
         end
      end
   end

   p_desel_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !cs |=> !rd_active);
   p_wait_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == F_WAIT && !(rise && din)) |=> (st == F_WAIT));
   p_done_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (st == F_DONE && cs) |=> (st == F_DONE));
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
   parameter int PROG_CYCLES = 24
)(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int TW = $clog2(PROG_CYCLES + 1);

   generate
      if (PROG_CYCLES < 1) begin : g_bad_len
         $error("PROG_CYCLES must be at least 1");
      end
   endgenerate

   logic [TW-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          left <= '0;
      else if (start)      left <= TW'(PROG_CYCLES);
      else if (left != '0) left <= left - 1'b1;
   end

   assign busy = (left != '0);

   p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);
   p_idle_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> !busy);
endmodule

// File: rtl/mw_lane_mem.sv
module mw_lane_mem #(
   parameter int WORD_AW = 10,
   parameter int BYTE_W  = 8
)(
   input  logic                clk,
   input  logic                wide,
   input  logic [WORD_AW:0]    rd_addr,
   output logic [2*BYTE_W-1:0] rd_data,
   input  logic                we,
   input  logic                eral,
   input  logic [WORD_AW:0]    wr_addr,
   input  logic [2*BYTE_W-1:0] wr_data
);
   localparam int DEPTH = 1 << WORD_AW;

   logic [WORD_AW-1:0] ridx, widx;
   logic [BYTE_W-1:0]  lane_q [2];

   assign ridx = wide ? rd_addr[WORD_AW-1:0] : rd_addr[WORD_AW:1];
   assign widx = wide ? wr_addr[WORD_AW-1:0] : wr_addr[WORD_AW:1];

   for (genvar g = 0; g < 2; g++) begin : g_lane
      logic [BYTE_W-1:0] mem [DEPTH];
      logic              hit;
      logic [BYTE_W-1:0] wbyte;

      assign hit   = wide | (wr_addr[0] == 1'(g));
      assign wbyte = wide ? wr_data[g*BYTE_W +: BYTE_W] : wr_data[BYTE_W-1:0];

      always_ff @(posedge clk) begin
         if (eral) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
         end else if (we && hit) begin
            mem[widx] <= wbyte;
         end
      end

      assign lane_q[g] = mem[ridx];
   end

   assign rd_data = wide ? {lane_q[1], lane_q[0]} : {lane_q[rd_addr[0]], {BYTE_W{1'b0}}};
endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave
   import mw_pkg::*;
#(
   parameter int WORD_AW     = 10,
   parameter int BYTE_W      = 8,
   parameter int PROG_CYCLES = 24
)(
   input  logic clk,
   input  logic rst_n,
   input  logic cs,
   input  logic sclk,
   input  logic din,
   input  logic org_wide,
   input  logic prog_en,
   output logic dout,
   output logic dout_oe
);
   localparam int DW = 2 * BYTE_W;

   generate
      if (WORD_AW < 3) begin : g_bad_aw
         $error("WORD_AW must be at least 3");
      end
      if (BYTE_W < 2) begin : g_bad_bw
         $error("BYTE_W must be at least 2");
      end
   endgenerate

   cmd_ev_t            ev;
   logic [WORD_AW:0]   rd_addr, cmd_addr;
   logic [DW-1:0]      rd_data, cmd_data, wr_data;
   logic               wide, rd_active, rd_bit, start_seen, busy;
   logic               wr_en_q, stat_show, allowed, prog_req, prog_go;

   mw_cmd_front #(.WORD_AW(WORD_AW), .BYTE_W(BYTE_W)) u_front (
      .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .din(din), .org_wide(org_wide),
      .busy(busy), .rd_data(rd_data), .rd_addr(rd_addr), .wide(wide),
      .rd_active(rd_active), .rd_bit(rd_bit), .start_seen(start_seen), .ev(ev),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data));

   assign allowed  = wr_en_q & prog_en;
   assign prog_req = ev.wr | ev.er | ev.eral;
   assign prog_go  = allowed & prog_req;
   assign wr_data  = ev.er ? '1 : cmd_data;

   mw_lane_mem #(.WORD_AW(WORD_AW), .BYTE_W(BYTE_W)) u_mem (
      .clk(clk), .wide(wide), .rd_addr(rd_addr), .rd_data(rd_data),
      .we(allowed & (ev.wr | ev.er)), .eral(allowed & ev.eral),
      .wr_addr(cmd_addr), .wr_data(wr_data));

   mw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(prog_go), .busy(busy));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en_q   <= 1'b0;
         stat_show <= 1'b0;
      end else begin
         if (ev.en)        wr_en_q <= 1'b1;
         else if (ev.dis)  wr_en_q <= 1'b0;
         if (prog_go)          stat_show <= 1'b1;
         else if (start_seen)  stat_show <= 1'b0;
      end
   end

   assign dout_oe = cs & (rd_active | stat_show);
   assign dout    = dout_oe & (rd_active ? rd_bit : ~busy);

   p_protect_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_req && !allowed) |=> !busy);
   p_status_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && stat_show) |=> stat_show);
endmodule

// File: tb/mw_eeprom_slave_test.sv
module mw_eeprom_slave_test;
   localparam int AW = 10;
   localparam int PC = 24;

   logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sclk = 1'b0, din = 1'b0;
   logic org_wide = 1'b1, prog_en = 1'b1;
   logic dout, dout_oe;
   int   n_chk = 0, n_fail = 0;
   logic [7:0] model [0:2047];

   always #5 clk = ~clk;

   mw_eeprom_slave #(.WORD_AW(AW), .BYTE_W(8), .PROG_CYCLES(PC)) uut (
      .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .din(din),
      .org_wide(org_wide), .prog_en(prog_en), .dout(dout), .dout_oe(dout_oe));

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic int alen(input logic w);
      return w ? AW : AW + 1;
   endfunction

   task automatic sbit(input logic b);
      @(negedge clk); din = b; sclk = 1'b0;
      repeat (2) @(negedge clk);
      sclk = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic send(input logic [31:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) sbit(v[i]);
   endtask

   task automatic sel(input logic w);
      @(negedge clk); org_wide = w; cs = 1'b1; sclk = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic desel();
      @(negedge clk); cs = 1'b0; sclk = 1'b0; din = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic wait_ready();
      repeat (PC + 6) @(negedge clk);
   endtask

   task automatic special(input logic w, input logic [1:0] sub);
      sel(w); sbit(1'b1); send(0, 2); send(sub, 2); send(0, alen(w) - 2);
   endtask

   task automatic write_cmd(input logic w, input logic [31:0] a, input logic [15:0] d);
      sel(w); sbit(1'b1); send(2'b01, 2); send(a, alen(w)); send(d, w ? 16 : 8);
   endtask

   task automatic model_write(input logic w, input int a, input logic [15:0] d);
      if (w) begin model[2*a] = d[7:0]; model[2*a+1] = d[15:8]; end
      else model[a] = d[7:0];
   endtask

   task automatic read_body(input logic w, input int a0, input int n, input string req);
      sbit(1'b1); send(2'b10, 2); send(a0, alen(w));
      chk(dout_oe === 1'b1 && dout === 1'b0, req, "dummy zero", {dout_oe, dout}, 2'b10);
      for (int k = 0; k < n; k++) begin
         int a;
         logic [15:0] exp, got;
         a   = (a0 + k) % (w ? 1024 : 2048);
         exp = w ? {model[2*a+1], model[2*a]} : {8'h00, model[a]};
         got = '0;
         for (int b = 0; b < (w ? 16 : 8); b++) begin
            sbit(1'b0);
            got = {got[14:0], dout};
         end
         chk(got === exp, req, $sformatf("data at %0h", a), got, exp);
      end
   endtask

   task automatic read_check(input logic w, input int a0, input int n, input string req);
      sel(w); read_body(w, a0, n, req); desel();
   endtask

   task automatic t_reset();
      chk(dout_oe === 1'b0, "R1", "oe in reset", dout_oe, 0);
      repeat (3) @(negedge clk); rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(dout_oe === 1'b0, "R1", "oe deselected", dout_oe, 0);
      sel(1'b1);
      chk(dout_oe === 1'b0, "R1", "oe selected idle", dout_oe, 0);
      desel();
      write_cmd(1'b1, 3, 16'h1234);
      chk(dout_oe === 1'b0, "R1", "no cycle before enable", dout_oe, 0);
      desel();
   endtask

   task automatic t_eral();
      special(1'b1, 2'b11); desel();
      special(1'b0, 2'b10);
      chk(dout_oe === 1'b1 && dout === 1'b0, "R8", "busy after erase-all", {dout_oe, dout}, 2'b10);
      wait_ready();
      chk(dout_oe === 1'b1 && dout === 1'b1, "R8", "ready after cycle", {dout_oe, dout}, 2'b11);
      desel();
      for (int i = 0; i < 2048; i++) model[i] = 8'hFF;
      read_check(1'b1, 0, 1, "R6");
      read_check(1'b1, 3, 1, "R6");
      read_check(1'b1, 1023, 1, "R6");
   endtask

   task automatic t_write_read();
      write_cmd(1'b1, 5, 16'hA5C3); wait_ready(); desel(); model_write(1'b1, 5, 16'hA5C3);
      read_check(1'b1, 5, 1, "R3");
      write_cmd(1'b0, 11'h7FF, 16'h005A); wait_ready(); desel(); model_write(1'b0, 2047, 16'h5A);
      read_check(1'b0, 11'h7FF, 1, "R3");
      read_check(1'b1, 1023, 1, "R5");
      write_cmd(1'b0, 11'h00A, 16'h0011); wait_ready(); desel(); model_write(1'b0, 10, 16'h11);
      read_check(1'b1, 5, 1, "R5");
   endtask

   task automatic t_seq_read();
      read_check(1'b1, 1022, 3, "R4");
      read_check(1'b0, 11'h7FE, 3, "R4");
   endtask

   task automatic t_erase();
      sel(1'b1); sbit(1'b1); send(2'b11, 2); send(5, AW); wait_ready(); desel();
      model_write(1'b1, 5, 16'hFFFF);
      read_check(1'b1, 5, 1, "R6");
      sel(1'b0); sbit(1'b1); send(2'b11, 2); send(11'h7FF, AW + 1); wait_ready(); desel();
      model[2047] = 8'hFF;
      read_check(1'b0, 11'h7FF, 1, "R6");
   endtask

   task automatic t_protect();
      prog_en = 1'b0;
      write_cmd(1'b1, 6, 16'h1111);
      chk(dout_oe === 1'b0, "R7", "no cycle with prog_en low", dout_oe, 0);
      desel(); prog_en = 1'b1;
      read_check(1'b1, 6, 1, "R7");
      special(1'b1, 2'b00); desel();
      write_cmd(1'b1, 9, 16'h1357);
      chk(dout_oe === 1'b0, "R7", "no cycle after disable", dout_oe, 0);
      desel();
      read_check(1'b1, 9, 1, "R7");
      read_check(1'b1, 3, 1, "R7");
      special(1'b1, 2'b11); desel();
   endtask

   task automatic t_busy_desel();
      write_cmd(1'b1, 7, 16'h0BEE); desel(); model_write(1'b1, 7, 16'h0BEE);
      sel(1'b1);
      chk(dout_oe === 1'b1 && dout === 1'b0, "R9", "busy after reselect", {dout_oe, dout}, 2'b10);
      wait_ready();
      chk(dout_oe === 1'b1 && dout === 1'b1, "R9", "ready after reselect", {dout_oe, dout}, 2'b11);
      desel();
      read_check(1'b1, 7, 1, "R9");
   endtask

   task automatic t_busy_start();
      write_cmd(1'b1, 8, 16'h4242); desel(); model_write(1'b1, 8, 16'h4242);
      sel(1'b1); sbit(1'b1);
      chk(dout_oe === 1'b1 && dout === 1'b0, "R10", "start ignored while busy", {dout_oe, dout}, 2'b10);
      wait_ready();
      chk(dout_oe === 1'b1 && dout === 1'b1, "R8", "status held until start", {dout_oe, dout}, 2'b11);
      sbit(1'b1);
      chk(dout_oe === 1'b0, "R8", "status cleared by start", dout_oe, 0);
      desel();
      read_check(1'b1, 8, 1, "R10");
   endtask

   task automatic t_idle_clocks();
      sel(1'b1); send(0, 6);
      chk(dout_oe === 1'b0, "R2", "idle clocks", dout_oe, 0);
      read_body(1'b1, 5, 1, "R2");
      desel();
   endtask

   task automatic t_abort();
      sel(1'b1); sbit(1'b1); send(2'b01, 2); send(3'b101, 3); desel();
      read_check(1'b1, 5, 1, "R11");
   endtask

   task automatic t_done_ignore();
      special(1'b1, 2'b11);
      sbit(1'b1); send(2'b10, 2); send(5, AW);
      chk(dout_oe === 1'b0, "R12", "clocks after command", dout_oe, 0);
      sbit(1'b0);
      chk(dout_oe === 1'b0, "R12", "still ignored", dout_oe, 0);
      desel();
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      t_reset();
      t_eral();
      t_write_read();
      t_seq_read();
      t_erase();
      t_protect();
      t_busy_desel();
      t_busy_start();
      t_idle_clocks();
      t_abort();
      t_done_ignore();
      summary();
      $finish;
   end
endmodule